// File: doc/BRIEF.md
# Posted-Write Interval Timer

This block is an up-counting interval timer that sits on a simple single-cycle register bus. Software programs a start value, a reload value and a compare value. It then starts the count and gets overflow and match events as sticky flags. Each flag feeds an interrupt line and a wakeup line through two independent enable masks. The count advances on every clock cycle in which the tick enable input is high and the run bit is set. The count value can be read at any time as a live timestamp.

Writes to the control, count, reload, reload-trigger and compare registers are posted. A write is taken at once, but it only takes effect a fixed number of cycles later. During that window a per-register bit in the pending register stays high, so software can poll it before relying on the new value. The flag register is write-one-to-clear: reading it and writing the value back clears exactly the flags that were seen. The enable masks are written directly and are not posted.

Reads are combinational from the address. The bus has no back-pressure: every access completes in the cycle it is presented.

Top module: `post_timer`

## Requirements
- R1: After reset the count, control, flag, enable and pending registers read 0, both irq_o and wake_o are low, offset 0x00 reads the constant 0x00000015 (writes to it are ignored) and offset 0x14 reads 1. Unmapped offsets read 0.
- R2: A write to control (0x24), count (0x28), reload (0x2C), trigger (0x30) or compare (0x38) sets pending bit 0, 1, 2, 3 or 4 of offset 0x34, respectively. The bit reads 1 for exactly POST_DLY (default 2) cycles after the write edge. The new value takes effect on the edge where the bit falls.
- R3: With control bit 0 (run) set, the count rises by one on each clock where tick_i is high. With tick_i low, or with run clear, the count holds.
- R4: When the count steps from 0xFFFFFFFF, flag bit 1 (overflow) of 0x18 sets on that same edge. The count becomes the reload value if control bit 1 (auto-reload) is set, and 0 otherwise.
- R5: With control bit 6 (compare enable) set, flag bit 0 (match) sets one edge after the count becomes equal to the compare value. It is recorded once per stretch of equality: once cleared, it stays clear while the count remains equal.
- R6: Writing offset 0x18 clears each flag whose written bit is 1 and leaves flags written with 0 unchanged. A new event wins over a clear in the same cycle.
- R7: irq_o is high exactly when some flag is set whose bit in the interrupt mask (0x1C, bits 2:0) is set. wake_o does the same with the wakeup mask (0x20, bits 2:0). Both masks read back bits 2:0 only.
- R8: A write of any value to 0x30 loads the count from the reload register when its posting completes. A count write completing in the same cycle takes priority. Offset 0x30 reads 0.
- R9: A count write takes effect while the timer runs, and counting continues from the written value on the next tick.
- R10: Flag bit 2 (capture) never sets. Control bits 14:7 and the prescale bits 5:2 are stored and read back, but do not change the counting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_i | input | 1 | Count enable, one count step per high cycle |
| bus_sel_i | input | 1 | Bus access strobe |
| bus_wr_i | input | 1 | 1 for write, 0 for read |
| bus_addr_i | input | AW (8) | Byte offset |
| bus_wdata_i | input | DW (32) | Write data |
| bus_rdata_o | output | DW (32) | Read data, combinational from address |
| irq_o | output | 1 | Interrupt request |
| wake_o | output | 1 | Wakeup request |

## Verification
The bench builds the block with its defaults: a 32-bit data path and a posting delay of two cycles. With this delay, the pending bit can be sampled in both of its high cycles and on the cycle it falls. Wrap-around is reached by loading the count near all-ones and gating tick_i, so an exact number of steps lands on the wrap or on the compare value. Both reload choices are checked this way, as are the clear-while-equal case for the match flag and a count write into a running timer.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam int unsigned OFF_REV    = 'h00;
  localparam int unsigned OFF_RDONE  = 'h14;
  localparam int unsigned OFF_FLAGS  = 'h18;
  localparam int unsigned OFF_IMASK  = 'h1C;
  localparam int unsigned OFF_WMASK  = 'h20;
  localparam int unsigned OFF_CTRL   = 'h24;
  localparam int unsigned OFF_COUNT  = 'h28;
  localparam int unsigned OFF_RELOAD = 'h2C;
  localparam int unsigned OFF_TRIG   = 'h30;
  localparam int unsigned OFF_PEND   = 'h34;
  localparam int unsigned OFF_CMP    = 'h38;

  localparam int CTRL_W  = 15;
  localparam int EV_W    = 3;
  localparam int NPOST   = 5;

  localparam int C_RUN   = 0;
  localparam int C_AUTO  = 1;
  localparam int C_CMPEN = 6;

  localparam int EV_MATCH = 0;
  localparam int EV_OVF   = 1;
  localparam int EV_CAPT  = 2;

  typedef enum int {
    PW_CTRL   = 0,
    PW_COUNT  = 1,
    PW_RELOAD = 2,
    PW_TRIG   = 3,
    PW_CMP    = 4
  } post_idx_e;

  function automatic int unsigned post_off(int idx);
    case (idx)
      PW_CTRL:   post_off = OFF_CTRL;
      PW_COUNT:  post_off = OFF_COUNT;
      PW_RELOAD: post_off = OFF_RELOAD;
      PW_TRIG:   post_off = OFF_TRIG;
      default:   post_off = OFF_CMP;
    endcase
  endfunction
endpackage

// File: rtl/tmr_post.sv
module tmr_post #(
  parameter int DW  = 32,
  parameter int DLY = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_i,
  input  logic [DW-1:0] d_i,
  output logic [DW-1:0] q_o,
  output logic          commit_o,
  output logic          pend_o
);
  localparam int CW = $clog2(DLY + 1);

  logic [CW-1:0] cnt_q;
  logic [DW-1:0] d_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      d_q   <= '0;
    end else if (wr_i) begin
      cnt_q <= CW'(DLY);
      d_q   <= d_i;
    end else if (cnt_q != '0) begin
      cnt_q <= cnt_q - CW'(1);
    end
  end

  assign q_o      = d_q;
  assign pend_o   = (cnt_q != '0);
  assign commit_o = (cnt_q == CW'(1)) && !wr_i;

  // R2
  pend_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_i |=> pend_o);

  // R2
  pend_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !pend_o && !wr_i |=> !pend_o);
endmodule

// File: rtl/tmr_count.sv
module tmr_count #(
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick_i,
  input  logic          run_i,
  input  logic          auto_i,
  input  logic          cmpen_i,
  input  logic [DW-1:0] reload_i,
  input  logic [DW-1:0] cmp_i,
  input  logic          ld_cnt_i,
  input  logic [DW-1:0] ld_val_i,
  input  logic          ld_trg_i,
  output logic [DW-1:0] cnt_o,
  output logic          ovf_o,
  output logic          mat_o
);
  logic [DW-1:0] cnt_q;
  logic          eq_q;
  logic          step;
  logic          eq_now;

  assign step   = run_i && tick_i && !ld_cnt_i && !ld_trg_i;
  assign eq_now = (cnt_q == cmp_i);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      eq_q  <= 1'b0;
    end else begin
      eq_q <= eq_now;
      if (ld_cnt_i)
        cnt_q <= ld_val_i;
      else if (ld_trg_i)
        cnt_q <= reload_i;
      else if (step) begin
        if (&cnt_q)
          cnt_q <= auto_i ? reload_i : '0;
        else
          cnt_q <= cnt_q + DW'(1);
      end
    end
  end

  assign cnt_o = cnt_q;
  assign ovf_o = step && (&cnt_q);
  assign mat_o = cmpen_i && eq_now && !eq_q;

  // R3
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(run_i && tick_i) && !ld_cnt_i && !ld_trg_i |=> $stable(cnt_q));

  // R4
  wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_o && auto_i |=> cnt_q == $past(reload_i));
endmodule

// File: rtl/tmr_flags.sv
module tmr_flags #(
  parameter int EW = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [EW-1:0] ev_i,
  input  logic          clr_i,
  input  logic [EW-1:0] clr_mask_i,
  input  logic [EW-1:0] imask_i,
  input  logic [EW-1:0] wmask_i,
  output logic [EW-1:0] flags_o,
  output logic          irq_o,
  output logic          wake_o
);
  logic [EW-1:0] flags_q;
  logic [EW-1:0] kill;

  assign kill = clr_i ? clr_mask_i : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flags_q <= '0;
    else        flags_q <= (flags_q & ~kill) | ev_i;
  end

  assign flags_o = flags_q;
  assign irq_o   = |(flags_q & imask_i);
  assign wake_o  = |(flags_q & wmask_i);

  // R4
  ovf_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev_i[1] |=> flags_q[1]);

  // R6
  clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr_i && clr_mask_i[0] && !ev_i[0] |=> !flags_q[0]);
endmodule

// File: rtl/post_timer.sv
module post_timer #(
  parameter int          AW       = 8,
  parameter int          DW       = 32,
  parameter int          POST_DLY = 2,
  parameter logic [31:0] REV_ID   = 32'h0000_0015
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick_i,
  input  logic          bus_sel_i,
  input  logic          bus_wr_i,
  input  logic [AW-1:0] bus_addr_i,
  input  logic [DW-1:0] bus_wdata_i,
  output logic [DW-1:0] bus_rdata_o,
  output logic          irq_o,
  output logic          wake_o
);
  import tmr_pkg::*;

  localparam logic [AW-1:0] A_REV    = AW'(OFF_REV);
  localparam logic [AW-1:0] A_RDONE  = AW'(OFF_RDONE);
  localparam logic [AW-1:0] A_FLAGS  = AW'(OFF_FLAGS);
  localparam logic [AW-1:0] A_IMASK  = AW'(OFF_IMASK);
  localparam logic [AW-1:0] A_WMASK  = AW'(OFF_WMASK);
  localparam logic [AW-1:0] A_CTRL   = AW'(OFF_CTRL);
  localparam logic [AW-1:0] A_COUNT  = AW'(OFF_COUNT);
  localparam logic [AW-1:0] A_RELOAD = AW'(OFF_RELOAD);
  localparam logic [AW-1:0] A_PEND   = AW'(OFF_PEND);
  localparam logic [AW-1:0] A_CMP    = AW'(OFF_CMP);

  logic              wr_go;
  logic [NPOST-1:0]  hit;
  logic [NPOST-1:0]  commit;
  logic [NPOST-1:0]  pend;
  logic [DW-1:0]     pdata [NPOST];

  logic [CTRL_W-1:0] ctrl_q;
  logic [DW-1:0]     reload_q;
  logic [DW-1:0]     cmp_q;
  logic [EV_W-1:0]   imask_q;
  logic [EV_W-1:0]   wmask_q;

  logic [DW-1:0]     cnt;
  logic              ovf_ev;
  logic              mat_ev;
  logic [EV_W-1:0]   ev;
  logic [EV_W-1:0]   flags;
  logic              flag_clr;
  logic              unused_trg;

  assign wr_go = bus_sel_i && bus_wr_i;

  for (genvar g = 0; g < NPOST; g++) begin : g_post
    assign hit[g] = wr_go && (bus_addr_i == AW'(post_off(g)));
    tmr_post #(.DW(DW), .DLY(POST_DLY)) u_post (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_i     (hit[g]),
      .d_i      (bus_wdata_i),
      .q_o      (pdata[g]),
      .commit_o (commit[g]),
      .pend_o   (pend[g])
    );
  end

  assign unused_trg = ^pdata[PW_TRIG];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q   <= '0;
      reload_q <= '0;
      cmp_q    <= '0;
      imask_q  <= '0;
      wmask_q  <= '0;
    end else begin
      if (commit[PW_CTRL])   ctrl_q   <= pdata[PW_CTRL][CTRL_W-1:0];
      if (commit[PW_RELOAD]) reload_q <= pdata[PW_RELOAD];
      if (commit[PW_CMP])    cmp_q    <= pdata[PW_CMP];
      if (wr_go && bus_addr_i == A_IMASK) imask_q <= bus_wdata_i[EV_W-1:0];
      if (wr_go && bus_addr_i == A_WMASK) wmask_q <= bus_wdata_i[EV_W-1:0];
    end
  end

  tmr_count #(.DW(DW)) u_count (
    .clk      (clk),
    .rst_n    (rst_n),
    .tick_i   (tick_i),
    .run_i    (ctrl_q[C_RUN]),
    .auto_i   (ctrl_q[C_AUTO]),
    .cmpen_i  (ctrl_q[C_CMPEN]),
    .reload_i (reload_q),
    .cmp_i    (cmp_q),
    .ld_cnt_i (commit[PW_COUNT]),
    .ld_val_i (pdata[PW_COUNT]),
    .ld_trg_i (commit[PW_TRIG]),
    .cnt_o    (cnt),
    .ovf_o    (ovf_ev),
    .mat_o    (mat_ev)
  );

  always_comb begin
    ev           = '0;
    ev[EV_MATCH] = mat_ev;
    ev[EV_OVF]   = ovf_ev;
  end

  assign flag_clr = wr_go && (bus_addr_i == A_FLAGS);

  tmr_flags #(.EW(EV_W)) u_flags (
    .clk        (clk),
    .rst_n      (rst_n),
    .ev_i       (ev),
    .clr_i      (flag_clr),
    .clr_mask_i (bus_wdata_i[EV_W-1:0]),
    .imask_i    (imask_q),
    .wmask_i    (wmask_q),
    .flags_o    (flags),
    .irq_o      (irq_o),
    .wake_o     (wake_o)
  );

  always_comb begin
    case (bus_addr_i)
      A_REV:    bus_rdata_o = DW'(REV_ID);
      A_RDONE:  bus_rdata_o = DW'(1);
      A_FLAGS:  bus_rdata_o = DW'(flags);
      A_IMASK:  bus_rdata_o = DW'(imask_q);
      A_WMASK:  bus_rdata_o = DW'(wmask_q);
      A_CTRL:   bus_rdata_o = DW'(ctrl_q);
      A_COUNT:  bus_rdata_o = cnt;
      A_RELOAD: bus_rdata_o = reload_q;
      A_PEND:   bus_rdata_o = DW'(pend);
      A_CMP:    bus_rdata_o = cmp_q;
      default:  bus_rdata_o = '0;
    endcase
  end

  // R10
  capt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !flags[EV_CAPT]);
endmodule

// File: tb/sim_post_timer.sv
module sim_post_timer;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick = 1'b1;
  logic        sel = 1'b0;
  logic        wr = 1'b0;
  logic [7:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        irq;
  logic        wake;

  int errors = 0;
  int checks = 0;
  int cyc = 0;

  always #5 clk = ~clk;

  post_timer u0 (
    .clk(clk), .rst_n(rst_n), .tick_i(tick),
    .bus_sel_i(sel), .bus_wr_i(wr), .bus_addr_i(addr),
    .bus_wdata_i(wdata), .bus_rdata_o(rdata),
    .irq_o(irq), .wake_o(wake)
  );

  localparam int NV = 7;
  localparam logic [7:0]  VA [NV] = '{8'h2C, 8'h38, 8'h1C, 8'h20, 8'h24, 8'h3C, 8'h00};
  localparam logic [31:0] VW [NV] = '{32'hA5A5_0001, 32'hDEAD_BEEF, 32'hFFFF_FFFF,
                                      32'h0000_0006, 32'h0000_7FBC, 32'h0000_1234, 32'h0000_FFFF};
  localparam logic [31:0] VE [NV] = '{32'hA5A5_0001, 32'hDEAD_BEEF, 32'h0000_0007,
                                      32'h0000_0006, 32'h0000_7FBC, 32'h0000_0000, 32'h0000_0015};

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic bw(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    sel = 1'b1; wr = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    sel = 1'b0; wr = 1'b0;
  endtask

  task automatic peek(input logic [7:0] a, output logic [31:0] v);
    addr = a;
    #1;
    v = rdata;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] v);
    @(negedge clk);
    peek(a, v);
  endtask

  task automatic ticks(input int n);
    @(negedge clk);
    tick = 1'b1;
    repeat (n) @(negedge clk);
    tick = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      errors++;
      checks++;
      $display("FAIL watchdog: got %0d expected below 100000 cycles", cyc);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [31:0] v, v2;
    idle(3);
    rst_n = 1'b1;
    // R1 reset state
    rd(8'h28, v); chk("R1 count", v, 0);
    peek(8'h24, v); chk("R1 ctrl", v, 0);
    peek(8'h18, v); chk("R1 flags", v, 0);
    peek(8'h34, v); chk("R1 pend", v, 0);
    chk("R1 irq", {31'b0, irq}, 0);
    chk("R1 wake", {31'b0, wake}, 0);
    peek(8'h00, v); chk("R1 rev", v, 32'h15);
    peek(8'h14, v); chk("R1 rdone", v, 1);

    // R2 R7 R10 R1 register table
    for (int i = 0; i < NV; i++) begin
      bw(VA[i], VW[i]);
      idle(3);
      peek(VA[i], v);
      chk("R2 table readback", v, VE[i]);
    end
    bw(8'h24, 0); bw(8'h1C, 0); bw(8'h20, 0);
    idle(3);

    // R2 posting of a count write
    bw(8'h28, 32'h77);
    peek(8'h34, v); chk("R2 pend first cycle", v, 32'h02);
    peek(8'h28, v); chk("R2 old count held", v, 0);
    rd(8'h34, v); chk("R2 pend second cycle", v, 32'h02);
    rd(8'h34, v); chk("R2 pend cleared", v, 0);
    peek(8'h28, v); chk("R2 count applied", v, 32'h77);

    // R9 count write while running
    tick = 1'b1;
    bw(8'h24, 1);
    idle(3);
    bw(8'h28, 32'h1000);
    rd(8'h28, v);
    rd(8'h28, v); chk("R9 written while running", v, 32'h1000);
    rd(8'h28, v); chk("R9 continues", v, 32'h1001);

    // R3 counting rate and hold
    rd(8'h28, v);
    idle(4);
    rd(8'h28, v2); chk("R3 five steps", v2 - v, 5);
    tick = 1'b0;
    rd(8'h28, v);
    idle(3);
    rd(8'h28, v2); chk("R3 hold tick low", v2, v);

    // R4 wrap with auto-reload
    bw(8'h24, 0); bw(8'h2C, 32'h1234); bw(8'h28, 32'hFFFF_FFFE);
    bw(8'h1C, 32'h2);
    bw(8'h24, 3);
    idle(3);
    bw(8'h18, 7);
    peek(8'h28, v); chk("R4 preload", v, 32'hFFFF_FFFE);
    ticks(2);
    peek(8'h28, v); chk("R4 reload on wrap", v, 32'h1234);
    peek(8'h18, v); chk("R4 overflow flag", v, 32'h2);
    chk("R7 irq on overflow", {31'b0, irq}, 1);
    chk("R7 wake masked", {31'b0, wake}, 0);
    // R6 clear semantics
    bw(8'h18, 1);
    peek(8'h18, v); chk("R6 zero bit keeps flag", v, 32'h2);
    bw(8'h18, 2);
    peek(8'h18, v); chk("R6 one bit clears flag", v, 0);
    chk("R7 irq drops", {31'b0, irq}, 0);

    // R4 wrap without auto-reload
    bw(8'h24, 1); bw(8'h28, 32'hFFFF_FFFF);
    idle(3);
    ticks(1);
    peek(8'h28, v); chk("R4 wrap to zero", v, 0);
    peek(8'h18, v); chk("R4 flag no reload", v, 32'h2);
    bw(8'h18, 7);

    // R5 match recorded once
    bw(8'h24, 0); bw(8'h28, 10); bw(8'h38, 12); bw(8'h20, 1);
    idle(3);
    bw(8'h24, 32'h41);
    idle(3);
    bw(8'h18, 7);
    ticks(2);
    peek(8'h28, v); chk("R5 at compare", v, 12);
    rd(8'h18, v); chk("R5 match flag", v, 32'h1);
    chk("R7 wake on match", {31'b0, wake}, 1);
    bw(8'h18, 1);
    idle(2);
    peek(8'h18, v); chk("R5 no re-set while equal", v, 0);
    ticks(1);
    idle(1);
    peek(8'h18, v); chk("R5 leaves equality quietly", v, 0);

    // R8 trigger reload
    bw(8'h24, 0); bw(8'h2C, 32'h55);
    idle(3);
    bw(8'h30, 32'hABCD);
    peek(8'h34, v); chk("R8 trigger pending bit", v, 32'h08);
    peek(8'h30, v); chk("R8 trigger reads zero", v, 0);
    idle(3);
    peek(8'h28, v); chk("R8 count from reload", v, 32'h55);

    // R10 capture flag never set
    peek(8'h18, v); chk("R10 capture bit", v & 32'h4, 0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule